// File: doc/BRIEF.md
# Framed Serial Readout Transmitter

This block sends 32-bit readout words over one serial data line, with a companion strobe line whose format is chosen at run time. Several devices share one link in a daisy chain: the device that holds the token transmits words from its own small FIFO, and every other device re-times the serial stream arriving from its upstream neighbour and passes it on. The re-timing uses the same serializing clock that transmission uses, so each hop adds exactly one bit period and delay does not build up along the chain.

Every word goes out as a frame of 35 bits: a start bit, the data word most significant bit first, an even parity bit and a stop bit. The bit rate comes from an integer divider of the core clock. The strobe can be held off, can copy the serializing clock, can toggle once per bit, or can follow a data-strobe scheme in which data and strobe together change exactly once per bit.

Top module: `srl_serial_tx`

## Requirements
- R1: In reset, and in the first cycle after it, `ser_data` and `ser_strb` are 0 and `wr_ready` is 1 (FIFO empty).
- R2: A frame is a 1 start bit, then `wr_data` bits 31 down to 0, then one parity bit making the count of ones across the 32 data bits and parity even, then a 0 stop bit. The frame occupies 35 consecutive bit periods, and a following frame may start in the very next bit period.
- R3: While `token_hold` is 1, no frame is in progress and the FIFO is empty, the line sends 0 in every bit period.
- R4: A bit period lasts `div_cfg`+1 core clocks. `div_cfg` = 0 gives one core clock per bit. `ser_data` changes only at a bit boundary.
- R5: With `strb_mode` = 2'b01 (clock), `ser_strb` is 0 for the first floor((`div_cfg`+1)/2) core clocks of each bit period and 1 for the rest.
- R6: With `strb_mode` = 2'b10 (edge), `ser_strb` toggles at every bit boundary and at no other time.
- R7: With `strb_mode` = 2'b11 (data-strobe), `ser_strb` toggles at a bit boundary exactly when the new bit equals the previous bit. This includes idle periods of 0, where it keeps toggling.
- R8: With `strb_mode` = 2'b00 (none), `ser_strb` is 0 from the next clock on.
- R9: When `token_hold` is 0 and no frame is in progress, each bit boundary copies the value of `up_sd` sampled at that clock edge onto `ser_data`.
- R10: A frame that has started completes even if `token_hold` falls during it. A new frame starts only at a bit boundary where `token_hold` is 1 and the FIFO holds a word.
- R11: The FIFO holds `FIFO_DEPTH` words. `wr_ready` is 0 while it is full, a write is taken only when `wr_valid` and `wr_ready` are both 1, and words are framed in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | DIV_W | Bit period minus one, in core clocks |
| strb_mode | input | 2 | Strobe format: 00 none, 01 clock, 10 edge, 11 data-strobe |
| token_hold | input | 1 | 1 while this device owns the link |
| wr_valid | input | 1 | Write request for the local FIFO |
| wr_data | input | WORD_W | Word to be sent |
| wr_ready | output | 1 | FIFO can accept a word |
| up_sd | input | 1 | Serial data from the upstream device |
| ser_data | output | 1 | Serial data line (registered) |
| ser_strb | output | 1 | Strobe line (registered) |

## Verification
If the bit divider state is wrong, edge-mode and data-strobe toggles land in the wrong cycles. A wrong divider also shifts `ser_data` transitions within one bit period, and a cycle-accurate comparison catches both at once. A shift register or bit counter that is off by one misplaces the parity or stop bit, or merges two frames. This shows at the port within 35 bit periods of the first word. A wrong FIFO count or pointer shows as `wr_ready` differing from the expected occupancy on the clock after the offending write or pop, or as words framed out of order. A mistake in the forwarding path shows as `ser_data` differing from the upstream bit of one boundary earlier.

// File: rtl/srl_tx_pkg.sv
package srl_tx_pkg;
  typedef enum logic [1:0] {
    STRB_NONE  = 2'd0,
    STRB_CLOCK = 2'd1,
    STRB_EDGE  = 2'd2,
    STRB_DS    = 2'd3
  } strb_mode_e;

  // start, parity and stop bits around each word
  localparam int FRAME_OVERHEAD = 3;
endpackage

// File: rtl/srl_bit_timer.sv
module srl_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  output logic [DIV_W-1:0] phase,
  output logic             bit_tick
);
  // last core clock of the current bit period
  assign bit_tick = (phase >= div_cfg);

  always_ff @(posedge clk) begin
    if (rst)           phase <= '0;
    else if (bit_tick) phase <= '0;
    else               phase <= phase + DIV_W'(1);
  end
endmodule

// File: rtl/srl_word_fifo.sv
module srl_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign wr_ready = (count < CW'(DEPTH));
  assign empty    = (count == '0);
  assign push     = wr_valid & wr_ready;
  assign pop      = rd_en & ~empty;
  assign rd_data  = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/srl_frame_shifter.sv
module srl_frame_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_tick,
  input  logic         token_hold,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_word,
  output logic         fifo_pop,
  input  logic         up_sd,
  output logic         line_q,
  output logic         line_nxt,
  output logic         busy
);
  localparam int FL = W + srl_tx_pkg::FRAME_OVERHEAD;
  localparam int CW = $clog2(FL);

  // bits still to send after the start bit: data, parity, stop
  logic [FL-2:0] shreg;
  logic [CW-1:0] left;
  logic          start;

  assign busy     = (left != '0);
  assign start    = bit_tick & ~busy & token_hold & ~fifo_empty;
  assign fifo_pop = start;

  always_comb begin
    if (!bit_tick)       line_nxt = line_q;
    else if (busy)       line_nxt = shreg[FL-2];
    else if (token_hold) line_nxt = start;
    else                 line_nxt = up_sd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      shreg  <= '0;
      left   <= '0;
    end else begin
      line_q <= line_nxt;
      if (bit_tick) begin
        if (busy) begin
          shreg <= shreg << 1;
          left  <= left - CW'(1);
        end else if (start) begin
          shreg <= {fifo_word, ^fifo_word, 1'b0};
          left  <= CW'(FL - 1);
        end
      end
    end
  end
endmodule

// File: rtl/srl_strobe_gen.sv
module srl_strobe_gen
  import srl_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strb_mode_e       mode,
  input  logic             bit_tick,
  input  logic [DIV_W-1:0] phase,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             line_q,
  input  logic             line_nxt,
  output logic             strb
);
  logic [DIV_W:0] half;
  logic [DIV_W:0] nph;
  logic           strb_d;

  assign half = ({1'b0, div_cfg} + (DIV_W+1)'(1)) >> 1;
  assign nph  = bit_tick ? '0 : ({1'b0, phase} + (DIV_W+1)'(1));

  always_comb begin
    case (mode)
      STRB_CLOCK: strb_d = (nph >= half);
      STRB_EDGE:  strb_d = bit_tick ? ~strb : strb;
      STRB_DS:    strb_d = (bit_tick && (line_nxt == line_q)) ? ~strb : strb;
      default:    strb_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) strb <= 1'b0;
    else     strb <= strb_d;
  end
endmodule

// File: rtl/srl_serial_tx.sv
module srl_serial_tx
  import srl_tx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [1:0]        strb_mode,
  input  logic              token_hold,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              up_sd,
  output logic              ser_data,
  output logic              ser_strb
);
  logic [DIV_W-1:0]  phase;
  logic              bit_tick;
  logic              fifo_empty;
  logic              fifo_pop;
  logic [WORD_W-1:0] fifo_word;
  logic              line_nxt;
  logic              tx_busy;

  srl_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .div_cfg(div_cfg),
    .phase(phase), .bit_tick(bit_tick)
  );

  srl_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_en(fifo_pop), .rd_data(fifo_word), .empty(fifo_empty)
  );

  srl_frame_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .token_hold(token_hold),
    .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_pop(fifo_pop),
    .up_sd(up_sd), .line_q(ser_data), .line_nxt(line_nxt), .busy(tx_busy)
  );

  srl_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst(rst), .mode(strb_mode_e'(strb_mode)),
    .bit_tick(bit_tick), .phase(phase), .div_cfg(div_cfg),
    .line_q(ser_data), .line_nxt(line_nxt), .strb(ser_strb)
  );
endmodule

// File: rtl/srl_tx_chk.sv
module srl_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] strb_mode,
  input logic       bit_tick,
  input logic       token_hold,
  input logic       busy,
  input logic       fifo_empty,
  input logic       ser_data,
  input logic       ser_strb
);
  // R4
  data_only_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(ser_data));

  // R6
  edge_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (strb_mode == 2'b10 && bit_tick) |=> (ser_strb != $past(ser_strb)));

  // R7
  ds_hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (strb_mode == 2'b11 && !bit_tick) |=> $stable(ser_strb));

  // R8
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (strb_mode == 2'b00) |=> !ser_strb);

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (token_hold && !busy && fifo_empty && bit_tick) |=> !ser_data);
endmodule

bind srl_serial_tx srl_tx_chk u_chk (
  .clk(clk), .rst(rst), .strb_mode(strb_mode), .bit_tick(bit_tick),
  .token_hold(token_hold), .busy(tx_busy), .fifo_empty(fifo_empty),
  .ser_data(ser_data), .ser_strb(ser_strb)
);

// File: tb/srl_serial_tx_tb.sv
`timescale 1ns/1ps
module srl_serial_tx_tb;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 8;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DIV_W-1:0]  div_cfg = '0;
  logic [1:0]        strb_mode = 2'b00;
  logic              token_hold = 1'b0;
  logic              wr_valid = 1'b0;
  logic [WORD_W-1:0] wr_data = '0;
  logic              wr_ready;
  logic              up_sd = 1'b0;
  logic              ser_data, ser_strb;

  int    checks = 0;
  int    errors = 0;
  string req = "R1";

  always #4 clk = ~clk;

  srl_serial_tx #(.WORD_W(WORD_W), .FIFO_DEPTH(DEPTH), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .div_cfg(div_cfg), .strb_mode(strb_mode),
    .token_hold(token_hold), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .up_sd(up_sd), .ser_data(ser_data), .ser_strb(ser_strb)
  );

  // behavioural reference: bit queue for the line, word queue for the FIFO
  bit               mq[$];
  logic [WORD_W-1:0] wq[$];
  int   m_ph = 0;
  bit   m_d = 0, m_s = 0, started = 0;

  always @(posedge clk) begin
    int sz0, dv;
    bit tick, nd, old;
    logic [WORD_W-1:0] w;
    started = 1;
    if (rst) begin
      m_ph = 0; m_d = 0; m_s = 0;
      mq.delete(); wq.delete();
    end else begin
      sz0 = wq.size();
      dv  = int'(div_cfg);
      tick = (m_ph >= dv);
      old = m_d;
      nd  = m_d;
      if (tick) begin
        if (mq.size() > 0) nd = mq.pop_front();
        else if (token_hold) begin
          if (sz0 > 0) begin
            w = wq.pop_front();
            for (int i = WORD_W - 1; i >= 0; i--) mq.push_back(w[i]);
            mq.push_back(^w);
            mq.push_back(1'b0);
            nd = 1'b1;
          end else nd = 1'b0;
        end else nd = up_sd;
      end
      m_ph = tick ? 0 : m_ph + 1;
      case (strb_mode)
        2'b01: m_s = (m_ph >= (dv + 1) / 2);
        2'b10: if (tick) m_s = ~m_s;
        2'b11: if (tick && nd == old) m_s = ~m_s;
        default: m_s = 1'b0;
      endcase
      m_d = nd;
      if (wr_valid && sz0 < DEPTH) wq.push_back(wr_data);
    end
  end

  always @(negedge clk) begin
    bit er;
    if (started) begin
      er = (wq.size() < DEPTH);
      checks++;
      if (ser_data !== m_d || ser_strb !== m_s || wr_ready !== er) begin
        errors++;
        $display("FAIL %s: data/strb/ready got %b%b%b expected %b%b%b at %0t",
                 req, ser_data, ser_strb, wr_ready, m_d, m_s, er, $time);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(input logic [WORD_W-1:0] w);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(4);
    // R1: reset state
    check_bit("R1 ser_data", ser_data, 1'b0);
    check_bit("R1 ser_strb", ser_strb, 1'b0);
    check_bit("R1 wr_ready", wr_ready, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R1 after release", ser_data, 1'b0);

    // R2 R3 R5: frames with clock strobe, then idle with token
    req = "R2 R3 R5"; div_cfg = 8'd3; strb_mode = 2'b01; token_hold = 1'b1;
    push_word(32'h8000_0001);
    push_word(32'h1234_5678);
    run(330);

    // R4 R6: one core clock per bit, edge strobe, extreme words
    req = "R4 R6"; div_cfg = 8'd0; strb_mode = 2'b10;
    push_word(32'hFFFF_FFFF);
    push_word(32'h0000_0000);
    run(90);

    // R7: data-strobe encoding, odd divider
    req = "R7 R2"; div_cfg = 8'd2; strb_mode = 2'b11;
    push_word(32'hA5A5_0F0F);
    push_word(32'h0000_0007);
    run(250);

    // R8: no strobe
    req = "R8"; div_cfg = 8'd1; strb_mode = 2'b00;
    push_word(32'hDEAD_BEEF);
    run(90);

    // R10 R9: drop token mid-frame, then forward upstream data
    req = "R10 R9"; strb_mode = 2'b11;
    push_word(32'hCAFE_F00D);
    run(20);
    token_hold = 1'b0;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      up_sd = 1'($urandom % 2);
    end
    up_sd = 1'b0;

    // R11: fill FIFO without token, then drain in order
    req = "R11";
    for (int i = 0; i < 10; i++) push_word(32'h0100_0000 * (i + 1) + 32'h55);
    check_bit("R11 full wr_ready", wr_ready, 1'b0);
    div_cfg = 8'd0; strb_mode = 2'b10; token_hold = 1'b1;
    run(DEPTH * 35 + 20);
    check_bit("R11 drained wr_ready", wr_ready, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule